// File: doc/BRIEF.md
# Triggered Capture Scope

An on-chip logic analyser core. Each cycle that the sample enable is high, the block stores one data word in a circular RAM. Once every RAM location has been written at least once, the scope becomes primed and can accept a trigger. The trigger can come from a wired input or from a write on the bus. After the trigger the scope keeps recording for a programmable number of enabled samples, called the holdoff, and then freezes. The frozen record shows what happened before the trigger and, depending on the holdoff, what followed it.

A small slave port carries two registers. Address 0 is a control word when written and a status word when read. Address 1 is a data port that returns the frozen samples oldest first, one sample per read, by unwrapping the circular buffer. An interrupt output stays high while the scope is frozen.

Top module: `trig_capture_scope`

## Requirements
- R1: On every cycle with `sampleEn` high while the scope is not stopped, `sampleData` is written at the current write pointer and the pointer then advances by one, wrapping silently at the RAM depth. Data presented while `sampleEn` is low is never recorded.
- R2: The primed flag sets on the enabled write to the last RAM location, which is the 2^LOG_DEPTH-th write after a re-arm. Until primed is set, both the wired trigger and a forced trigger are ignored. A trigger in the same cycle as the priming write is also ignored.
- R3: A trigger is latched on any clock once the scope is primed, whatever the state of `sampleEn`. When the trigger cycle has no enabled sample, the next enabled sample counts as the trigger sample.
- R4: After the trigger sample, exactly H further enabled samples are recorded and the scope then stops, where H is the holdoff. With H = 0 the trigger sample is the newest record.
- R5: Once stopped, the RAM contents and the write pointer are frozen until a re-arm.
- R6: Each read of address 1 returns RAM[write pointer + read offset] and then advances the read offset by one. Offsets wrap modulo the depth, so reads that start from offset 0 on a stopped scope return samples oldest to newest.
- R7: `busAck` rises exactly two clocks after each cycle with `busStb` high and at no other time. `busRdata` is valid with `busAck`, and the address registered at the strobe selects between the status word and the sample data.
- R8: The status word places stopped at bit 31, triggered at bit 30, primed at bit 29, wired-trigger-disable at bit 26, LOG_DEPTH at bits 24:20 and the holdoff at bits 19:0. All other bits read as zero.
- R9: A write to address 0 loads the holdoff from bits 19:0 and the wired-trigger-disable from bit 26. Bit 27 forces a trigger, subject to R2. Bit 31 requests a re-arm, which takes priority over bit 27.
- R10: A re-arm clears primed, triggered, stopped, the holdoff count, the write pointer and the read offset. The holdoff and disable values written in the same word take effect.
- R11: `stopIrq` is high exactly while the scope is stopped, and it drops on a re-arm.
- R12: After `rst`, all flags, the holdoff and the disable are zero and `busAck` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleEn | input | 1 | Sample valid / clock enable for recording |
| sampleData | input | DATA_W | Word to record |
| trigIn | input | 1 | Wired trigger |
| busStb | input | 1 | Bus strobe, one transfer per cycle |
| busWe | input | 1 | Bus write enable |
| busAddr | input | 1 | Register select: 0 control/status, 1 data |
| busWdata | input | 32 | Bus write data |
| busAck | output | 1 | Transfer acknowledge, two clocks after strobe |
| busRdata | output | 32 | Bus read data |
| stopIrq | output | 1 | High while the scope is stopped |

## Verification
The embedded assertions check on every cycle the two-cycle acknowledge, the write-pointer and read-offset steps, the clearing done by a re-arm, and that triggered never rises before primed. They also check that stopped implies triggered and stays set until re-armed. Whether the right samples end up in the record can only be shown by the bench's scenarios. These include where the trigger sample lands for holdoffs 0, 5 and 2, a trigger between enabled samples, a trigger blocked by the disable bit or by the priming threshold, and readback order after the offset wraps and after a re-arm.

// File: rtl/scope_pkg.sv
package scope_pkg;

  localparam int BUS_W = 32;

  // control-word bit positions (write to address 0)
  localparam int CTL_REARM  = 31;
  localparam int CTL_FORCE  = 27;
  localparam int CTL_NOEXT  = 26;

  // status-word bit positions (read of address 0)
  localparam int ST_STOPPED = 31;
  localparam int ST_TRIG    = 30;
  localparam int ST_PRIMED  = 29;
  localparam int ST_NOEXT   = 26;
  localparam int ST_LOG_LSB = 20;
  localparam int ST_LOG_W   = 5;
  localparam int HOLD_FIELD = 20;

  // strobes from control to datapath
  typedef struct packed {
    logic rearm;      // clear write pointer and read offset
    logic wrEn;       // store sample, advance write pointer
    logic rdAdvance;  // data-port read: advance read offset
  } scopeStrobe_t;

endpackage

// File: rtl/scope_ctrl.sv
module scope_ctrl
  import scope_pkg::*;
#(
  parameter int LOG_DEPTH = 5,
  parameter int HOLD_W    = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sampleEn,
  input  logic             trigIn,
  input  logic             busStb,
  input  logic             busWe,
  input  logic             busAddr,
  input  logic [BUS_W-1:0] busWdata,
  input  logic             wrapPoint,
  output scopeStrobe_t     st,
  output logic [BUS_W-1:0] statusWord,
  output logic             stopIrq
);

  localparam logic [ST_LOG_W-1:0] LOG_FIELD = ST_LOG_W'(LOG_DEPTH);

  logic              primed, triggered, stopped;
  logic              trigDisable;
  logic [HOLD_W-1:0] holdoff, holdCnt;
  logic              ctrlWrite, forceTrig, trigEvent, armedNow;
  logic              unusedBits;

  assign ctrlWrite = busStb && busWe && !busAddr;
  assign forceTrig = ctrlWrite && busWdata[CTL_FORCE] && !busWdata[CTL_REARM];
  assign trigEvent = primed && !triggered && !stopped &&
                     (forceTrig || (trigIn && !trigDisable));
  assign armedNow  = triggered || trigEvent;

  always_comb begin
    st.rearm     = rst || (ctrlWrite && busWdata[CTL_REARM]);
    st.wrEn      = sampleEn && !stopped;
    st.rdAdvance = busStb && !busWe && busAddr;
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      holdoff     <= '0;
      trigDisable <= 1'b0;
    end else if (ctrlWrite) begin
      holdoff     <= busWdata[HOLD_W-1:0];
      trigDisable <= busWdata[CTL_NOEXT];
    end
  end

  // capture state
  always_ff @(posedge clk) begin
    if (st.rearm) begin
      primed    <= 1'b0;
      triggered <= 1'b0;
      stopped   <= 1'b0;
      holdCnt   <= '0;
    end else begin
      if (trigEvent) triggered <= 1'b1;
      if (st.wrEn && wrapPoint) primed <= 1'b1;
      if (st.wrEn && armedNow) begin
        if (holdCnt >= holdoff) stopped <= 1'b1;
        else holdCnt <= holdCnt + 1'b1;
      end
    end
  end

  assign stopIrq = stopped;

  always_comb begin
    statusWord                                 = '0;
    statusWord[ST_STOPPED]                     = stopped;
    statusWord[ST_TRIG]                        = triggered;
    statusWord[ST_PRIMED]                      = primed;
    statusWord[ST_NOEXT]                       = trigDisable;
    statusWord[ST_LOG_LSB +: ST_LOG_W]         = LOG_FIELD;
    statusWord[HOLD_W-1:0]                     = holdoff;
  end

  assign unusedBits = ^{busWdata[30:28], busWdata[25:HOLD_W]};

  // R2: no trigger before the buffer is primed
  a_r2_trig_needs_primed: assert property (@(posedge clk) disable iff (rst)
    $rose(triggered) |-> $past(primed));

  a_r2_primed_sticky: assert property (@(posedge clk) disable iff (rst)
    (primed && !st.rearm) |=> primed);

  // R4: stopping only happens after a trigger
  a_r4_stop_implies_trig: assert property (@(posedge clk) disable iff (rst)
    stopped |-> triggered);

  // R5: frozen until re-arm
  a_r5_stop_sticky: assert property (@(posedge clk) disable iff (rst)
    (stopped && !st.rearm) |=> stopped);

  // R11: interrupt rises only after an enabled sample
  a_r11_irq_after_sample: assert property (@(posedge clk) disable iff (rst)
    $rose(stopIrq) |-> $past(sampleEn));

endmodule

// File: rtl/scope_datapath.sv
module scope_datapath
  import scope_pkg::*;
#(
  parameter int LOG_DEPTH = 5,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  scopeStrobe_t      st,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              busStb,
  input  logic              busAddr,
  input  logic [BUS_W-1:0]  statusWord,
  output logic              wrapPoint,
  output logic              busAck,
  output logic [BUS_W-1:0]  busRdata
);

  localparam int DEPTH  = 1 << LOG_DEPTH;
  localparam int ADDR_W = LOG_DEPTH;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wrAddr, rdOff, rdAddr;
  logic [DATA_W-1:0] ramQ;
  logic [BUS_W-1:0]  ramWide;
  logic              addrQ, ackPipe;

  assign wrapPoint = &wrAddr;
  assign rdAddr    = wrAddr + rdOff;

  always_ff @(posedge clk) begin
    if (st.rearm) wrAddr <= '0;
    else if (st.wrEn) wrAddr <= wrAddr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (st.wrEn) mem[wrAddr] <= sampleData;
  end

  always_ff @(posedge clk) begin
    if (st.rearm) rdOff <= '0;
    else if (st.rdAdvance) rdOff <= rdOff + 1'b1;
  end

  always_ff @(posedge clk) begin
    ramQ <= mem[rdAddr];
  end

  generate
    if (DATA_W < BUS_W) begin : g_pad
      assign ramWide = {{(BUS_W-DATA_W){1'b0}}, ramQ};
    end else begin : g_trunc
      assign ramWide = ramQ[BUS_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ackPipe <= 1'b0;
      busAck  <= 1'b0;
      addrQ   <= 1'b0;
    end else begin
      ackPipe <= busStb;
      busAck  <= ackPipe;
      addrQ   <= busAddr;
    end
  end

  always_ff @(posedge clk) begin
    busRdata <= addrQ ? ramWide : statusWord;
  end

  // R7: acknowledge exactly two clocks after a strobe
  a_r7_ack_two: assert property (@(posedge clk) disable iff (rst)
    busStb |-> ##2 busAck);

  a_r7_ack_none: assert property (@(posedge clk) disable iff (rst)
    !busStb |-> ##2 !busAck);

  // R1: pointer steps by one per recorded sample
  a_r1_addr_step: assert property (@(posedge clk) disable iff (rst)
    (st.wrEn && !st.rearm) |=> (wrAddr == ADDR_W'($past(wrAddr) + 1'b1)));

  // R6: offset steps by one per data read
  a_r6_offset_step: assert property (@(posedge clk) disable iff (rst)
    (st.rdAdvance && !st.rearm) |=> (rdOff == ADDR_W'($past(rdOff) + 1'b1)));

  // R10: re-arm clears both pointers
  a_r10_rearm_clear: assert property (@(posedge clk) disable iff (rst)
    st.rearm |=> (wrAddr == '0 && rdOff == '0));

endmodule

// File: rtl/trig_capture_scope.sv
module trig_capture_scope
  import scope_pkg::*;
#(
  parameter int LOG_DEPTH = 5,
  parameter int DATA_W    = 32,
  parameter int HOLD_W    = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sampleEn,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              trigIn,
  input  logic              busStb,
  input  logic              busWe,
  input  logic              busAddr,
  input  logic [31:0]       busWdata,
  output logic              busAck,
  output logic [31:0]       busRdata,
  output logic              stopIrq
);

  scopeStrobe_t     strobes;
  logic [BUS_W-1:0] statusWord;
  logic             wrapPoint;

  scope_ctrl #(.LOG_DEPTH(LOG_DEPTH), .HOLD_W(HOLD_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .sampleEn   (sampleEn),
    .trigIn     (trigIn),
    .busStb     (busStb),
    .busWe      (busWe),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .wrapPoint  (wrapPoint),
    .st         (strobes),
    .statusWord (statusWord),
    .stopIrq    (stopIrq)
  );

  scope_datapath #(.LOG_DEPTH(LOG_DEPTH), .DATA_W(DATA_W)) u_data (
    .clk        (clk),
    .rst        (rst),
    .st         (strobes),
    .sampleData (sampleData),
    .busStb     (busStb),
    .busAddr    (busAddr),
    .statusWord (statusWord),
    .wrapPoint  (wrapPoint),
    .busAck     (busAck),
    .busRdata   (busRdata)
  );

endmodule

// File: tb/test_trig_capture_scope.sv
module test_trig_capture_scope;

  localparam int LOGD  = 5;
  localparam int DEPTH = 1 << LOGD;

  logic        clk = 1'b0;
  logic        rst;
  logic        sampleEn, trigIn, busStb, busWe, busAddr;
  logic [31:0] sampleData, busWdata, busRdata;
  logic        busAck, stopIrq;

  always #5 clk = ~clk;  // 100 MHz

  trig_capture_scope #(.LOG_DEPTH(LOGD), .DATA_W(32), .HOLD_W(20)) i_trig_capture_scope (
    .clk(clk), .rst(rst), .sampleEn(sampleEn), .sampleData(sampleData),
    .trigIn(trigIn), .busStb(busStb), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busAck(busAck), .busRdata(busRdata), .stopIrq(stopIrq)
  );

  int errors = 0;
  int checks = 0;
  int nextVal = 1;
  bit done = 0;

  // scoreboard
  logic [31:0] expVal[$];
  string       expTag[$];
  bit          expCmp[$];
  logic [1:0]  stbHist;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] stat(bit s, bit t, bit p, bit dis, int h);
    return {s, t, p, 2'b00, dis, 1'b0, 5'(LOGD), 20'(h)};
  endfunction

  task automatic drive(bit en, bit trig, bit stb, bit we, bit a, logic [31:0] wd);
    sampleEn   = en;
    sampleData = en ? 32'(nextVal) : 32'hDEAD0000;
    if (en) nextVal++;
    trigIn   = trig;
    busStb   = stb;
    busWe    = we;
    busAddr  = a;
    busWdata = wd;
    @(posedge clk); #2;
  endtask

  task automatic cyc(bit en);      drive(en, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0); endtask
  task automatic trigCyc(bit en);  drive(en, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0); endtask
  task automatic idle(int n);      for (int i = 0; i < n; i++) cyc(1'b0);     endtask

  task automatic busWr(logic [31:0] d, string tag);
    expVal.push_back(32'h0); expTag.push_back(tag); expCmp.push_back(1'b0);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, d);
  endtask

  task automatic busRd(bit a, logic [31:0] exp, string tag);
    expVal.push_back(exp); expTag.push_back(tag); expCmp.push_back(1'b1);
    drive(1'b0, 1'b0, 1'b1, 1'b0, a, 32'h0);
  endtask

  // monitor: compares acknowledged read data against the queue (R7)
  always @(negedge clk) begin
    if (rst) begin
      stbHist <= 2'b00;
    end else begin
      if (busAck !== stbHist[1]) begin
        checks++; errors++;
        $display("FAIL R7 ack timing: actual=%b expected=%b", busAck, stbHist[1]);
      end
      if (busAck === 1'b1) begin
        if (expVal.size() == 0) begin
          checks++; errors++;
          $display("FAIL R7 ack with no pending transfer: actual=1 expected=0");
        end else begin
          logic [31:0] e;
          string       t;
          bit          c;
          e = expVal.pop_front(); t = expTag.pop_front(); c = expCmp.pop_front();
          if (c) check(t, busRdata, e);
        end
      end
      stbHist <= {stbHist[0], busStb};
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int v, t, f;
    rst = 1'b1;
    sampleEn = 0; sampleData = 0; trigIn = 0; busStb = 0; busWe = 0; busAddr = 0; busWdata = 0;
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    check("R12 busAck after reset", {31'h0, busAck}, 32'h0);
    check("R12 R11 stopIrq after reset", {31'h0, stopIrq}, 32'h0);
    @(posedge clk); #2;

    // reset status word and layout
    busRd(1'b0, stat(0, 0, 0, 0, 0), "R12 R8 reset status");

    // triggers before priming are ignored
    repeat (20) cyc(1'b1);
    trigCyc(1'b1);
    busRd(1'b0, stat(0, 0, 0, 0, 0), "R2 trigger before primed ignored");
    repeat (12) cyc(1'b1);
    busRd(1'b0, stat(0, 0, 1, 0, 0), "R2 primed after full pass");
    idle(3);
    check("R11 irq low while running", {31'h0, stopIrq}, 32'h0);

    // holdoff 0: trigger sample is newest
    v = nextVal;
    trigCyc(1'b1);
    repeat (5) cyc(1'b1);
    busRd(1'b0, stat(1, 1, 1, 0, 0), "R4 R8 stopped status holdoff 0");
    idle(3);
    check("R11 irq high when stopped", {31'h0, stopIrq}, 32'h1);
    for (int i = 0; i < DEPTH; i++) busRd(1'b1, 32'(v - (DEPTH - 1) + i), "R6 R4 readback holdoff 0");
    busRd(1'b1, 32'(v - (DEPTH - 1)), "R6 offset wrap");
    repeat (10) cyc(1'b1);
    busRd(1'b1, 32'(v - (DEPTH - 2)), "R5 R1 record frozen after stop");
    idle(4);

    // re-arm with holdoff 5
    busWr(32'h8000_0005, "R9 rearm write");
    idle(3);
    check("R11 irq cleared by rearm", {31'h0, stopIrq}, 32'h0);
    busRd(1'b0, stat(0, 0, 0, 0, 5), "R10 R9 flags cleared holdoff loaded");
    repeat (31) cyc(1'b1);
    trigCyc(1'b1);  // priming write: trigger ignored
    busRd(1'b0, stat(0, 0, 1, 0, 5), "R10 R2 write pointer cleared, trigger on priming write ignored");
    repeat (3) cyc(1'b1);
    t = nextVal;
    trigCyc(1'b0);  // trigger without enable
    busRd(1'b0, stat(0, 1, 1, 0, 5), "R3 trigger latched without enable");
    repeat (10) cyc(1'b1);
    busRd(1'b0, stat(1, 1, 1, 0, 5), "R4 stopped after holdoff 5");
    for (int i = 0; i < DEPTH; i++) busRd(1'b1, 32'(t + 5 - (DEPTH - 1) + i), "R6 R10 R4 readback holdoff 5");
    idle(4);

    // wired trigger disabled, forced trigger, gapped enable
    busWr(32'h8400_0002, "R9 rearm with disable");
    repeat (35) begin cyc(1'b1); cyc(1'b0); end
    trigCyc(1'b1);
    busRd(1'b0, stat(0, 0, 1, 1, 2), "R9 wired trigger disabled");
    f = nextVal;
    busWr(32'h0C00_0002, "R9 force trigger");
    repeat (8) begin cyc(1'b1); cyc(1'b0); end
    busRd(1'b0, stat(1, 1, 1, 1, 2), "R9 R4 forced trigger stopped");
    for (int i = 0; i < DEPTH; i++) busRd(1'b1, 32'(f + 2 - (DEPTH - 1) + i), "R9 R1 R6 readback forced holdoff 2");
    idle(5);
    check("R7 all transfers acknowledged", 32'(expVal.size()), 32'h0);

    done = 1;
    summary();
    $finish;
  end

endmodule